// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Burst Hold

This block decides which of five bus masters owns the address bus of an AHB-style interconnect. Every master has a request line. The arbiter picks the highest-ranked eligible requester and presents the choice as a registered one-hot grant vector. A separate 4-bit owner code follows that grant on the next cycle in which the bus is ready, so the owner code changes at the address-phase handover.

A master that receives a SPLIT response is taken out of contention until a slave signals that it may return. If no real master can be served, the arbiter parks the bus on a dummy owner. With burst hold enabled by a parameter, a fixed-length burst keeps its owner until its penultimate beat has been accepted, even if the owner drops its request during the burst. A RETRY or SPLIT response ends the hold at once and lets arbitration run immediately. An undefined-length burst and a single transfer are never held.

Top module: `prio_bus_arbiter`

## Requirements
- R1: The grant vector is all zeros or has exactly one bit set. The owner code is the master index (4'b0000 to 4'b0100), or 4'b1111 for the dummy owner.
- R2: Among the eligible requesters, the highest index wins: master 4 ranks above 3, 3 above 2, 2 above 1, and 1 above 0.
- R3: After reset, and whenever nothing requests and master 0 is not masked, master 0 holds the grant (grant 5'b00001, owner code 4'b0000).
- R4: Consider a SPLIT response (hresp 2'b11) seen while hready is low. It masks the master that owns the current data phase. A masked master is never granted. The mask bit clears on the cycle its bit of split_release_i is high.
- R5: The dummy owner (grant 5'b00000, code 4'b1111) is chosen when every requesting master is masked, and when master 0 is masked and no one else is eligible.
- R6: With HOLD_EN=1, a NONSEQ (htrans 2'b10) accepted with hburst 3'b010/3'b011 (4 beats), 3'b100/3'b101 (8 beats) or 3'b110/3'b111 (16 beats) freezes the grant. The grant stays frozen, even if the owner drops its request, until the accepted-beat count reaches length minus one. A SEQ (2'b11) accepted with hready high counts as one beat.
- R7: A RETRY (2'b10) or SPLIT (2'b11) response lets the grant change on that same clock edge, even when hready is low or a hold is active.
- R8: On every clock edge with hready high, the owner code takes the code of the grant that was registered before that edge.
- R9: While hready is low and the response is OKAY or ERROR, the grant does not change.
- R10: A NONSEQ with hburst 3'b000 or 3'b001 is never held. With HOLD_EN=0, arbitration runs on every cycle where hready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 5 | Bus request, one bit per master |
| split_release_i | input | 5 | Per-master release of a split mask |
| hready_i | input | 1 | Current transfer completes |
| htrans_i | input | 2 | Transfer type of the current address phase |
| hburst_i | input | 3 | Burst type of the current address phase |
| hresp_i | input | 2 | Slave response of the current data phase |
| grant_o | output | 5 | One-hot grant, all zeros for the dummy owner |
| owner_o | output | 4 | Code of the master owning the address phase |

## Verification
Two functions can land on the same clock edge: a burst hold that has not yet reached its penultimate beat, and an early-termination response that must override it. The bench runs an 8-beat burst, drops the owner's request mid-burst, and then issues a RETRY while hready is low. It checks that the grant moves to the waiting lower-ranked master on that same edge rather than after the remaining beats. The split mask has a similar overlap: the arbitration on the second SPLIT cycle must already see the freshly set mask, and the bench judges this by seeing the dummy owner on that edge.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [1:0] RSP_OKAY  = 2'b00;
  localparam logic [1:0] RSP_ERROR = 2'b01;
  localparam logic [1:0] RSP_RETRY = 2'b10;
  localparam logic [1:0] RSP_SPLIT = 2'b11;

  // Beats of a fixed-length burst; zero means never held.
  function automatic logic [4:0] burst_beats(input logic [2:0] kind);
    case (kind[2:1])
      2'b01:   burst_beats = 5'd4;
      2'b10:   burst_beats = 5'd8;
      2'b11:   burst_beats = 5'd16;
      default: burst_beats = 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int N    = 5,
  parameter int ID_W = 4
) (
  input  logic [N-1:0]    req,
  input  logic [N-1:0]    mask,
  output logic [N-1:0]    grant_n,
  output logic [ID_W-1:0] code_n
);
  localparam logic [ID_W-1:0] DUMMY = {ID_W{1'b1}};

  logic [N-1:0] elig;
  assign elig = req & ~mask;

  always_comb begin
    grant_n = '0;
    code_n  = '0;
    if (elig != '0) begin
      for (int i = 0; i < N; i++) begin
        if (elig[i]) begin
          grant_n = '0;
          grant_n[i] = 1'b1;
          code_n = ID_W'(i);
        end
      end
    end else if (req != '0 || mask[0]) begin
      grant_n = '0;
      code_n  = DUMMY;
    end else begin
      grant_n[0] = 1'b1;
      code_n     = '0;
    end
  end
endmodule

// File: rtl/arb_split_mask.sv
module arb_split_mask #(
  parameter int N    = 5,
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            split_hit,
  input  logic [ID_W-1:0] dph_id,
  input  logic [N-1:0]    release_i,
  output logic [N-1:0]    mask_q
);
  logic [N-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < N; i++)
      if (split_hit && dph_id == ID_W'(i)) set_vec[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= (mask_q & ~release_i) | set_vec;
  end
endmodule

// File: rtl/arb_burst_track.sv
module arb_burst_track
  import arb_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter bit HOLD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hready,
  input  logic [1:0]       htrans,
  input  logic [2:0]       hburst,
  input  logic             early,
  output logic             hold_blk,
  output logic             hold_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] len_q
);
  generate
    if (HOLD_EN) begin : g_hold
      logic [CNT_W-1:0] new_len;
      logic             starting;
      logic             seq_acc;
      logic [CNT_W-1:0] beats;

      assign new_len  = CNT_W'(burst_beats(hburst));
      assign starting = hready && htrans == TR_NONSEQ && new_len != '0;
      assign seq_acc  = hready && htrans == TR_SEQ && hold_q;
      assign beats    = cnt_q + CNT_W'(seq_acc);

      always_comb begin
        hold_blk = 1'b0;
        if (!early) begin
          if (starting) hold_blk = 1'b1;
          else if (hold_q && (htrans == TR_SEQ || htrans == TR_BUSY))
            hold_blk = beats < (len_q - CNT_W'(1));
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          hold_q <= 1'b0;
          cnt_q  <= '0;
          len_q  <= '0;
        end else if (early) begin
          hold_q <= 1'b0;
        end else if (hready) begin
          if (htrans == TR_NONSEQ) begin
            hold_q <= starting;
            cnt_q  <= CNT_W'(1);
            len_q  <= new_len;
          end else if (seq_acc) begin
            cnt_q <= beats;
            if (beats == len_q) hold_q <= 1'b0;
          end else if (htrans == TR_IDLE) begin
            hold_q <= 1'b0;
          end
        end
      end
    end else begin : g_nohold
      assign hold_blk = 1'b0;
      assign hold_q   = 1'b0;
      assign cnt_q    = '0;
      assign len_q    = '0;
    end
  endgenerate
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_MASTERS = 5,
  parameter int ID_W      = 4,
  parameter int CNT_W     = 5,
  parameter bit HOLD_EN   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [N_MASTERS-1:0] split_release_i,
  input  logic                 hready_i,
  input  logic [1:0]           htrans_i,
  input  logic [2:0]           hburst_i,
  input  logic [1:0]           hresp_i,
  output logic [N_MASTERS-1:0] grant_o,
  output logic [ID_W-1:0]      owner_o
);
  logic [N_MASTERS-1:0] mask_q;
  logic [N_MASTERS-1:0] grant_n;
  logic [ID_W-1:0]      code_n;
  logic [ID_W-1:0]      gid_q;
  logic [ID_W-1:0]      dph_q;
  logic                 early;
  logic                 hold_blk;
  logic                 hold_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     len_q;
  logic                 upd;

  assign early = hresp_i == RSP_RETRY || hresp_i == RSP_SPLIT;
  assign upd   = early || (hready_i && !hold_blk);

  arb_prio_pick #(.N(N_MASTERS), .ID_W(ID_W)) u_pick (
    .req(req_i), .mask(mask_q), .grant_n(grant_n), .code_n(code_n)
  );

  arb_split_mask #(.N(N_MASTERS), .ID_W(ID_W)) u_mask (
    .clk(clk), .rst(rst),
    .split_hit(hresp_i == RSP_SPLIT && !hready_i),
    .dph_id(dph_q), .release_i(split_release_i), .mask_q(mask_q)
  );

  arb_burst_track #(.CNT_W(CNT_W), .HOLD_EN(HOLD_EN)) u_track (
    .clk(clk), .rst(rst), .hready(hready_i), .htrans(htrans_i),
    .hburst(hburst_i), .early(early), .hold_blk(hold_blk),
    .hold_q(hold_q), .cnt_q(cnt_q), .len_q(len_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= N_MASTERS'(1);
      gid_q   <= '0;
      owner_o <= '0;
      dph_q   <= '0;
    end else begin
      if (upd) begin
        grant_o <= grant_n;
        gid_q   <= code_n;
      end
      if (hready_i) begin
        owner_o <= gid_q;
        dph_q   <= owner_o;
      end
    end
  end
endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk #(
  parameter int N     = 5,
  parameter int ID_W  = 4,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     grant,
  input logic [ID_W-1:0]  owner,
  input logic             hready,
  input logic [1:0]       htrans,
  input logic [1:0]       hresp,
  input logic [N-1:0]     mask,
  input logic             hold,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] len
);
  function automatic logic [ID_W-1:0] code_of(input logic [N-1:0] g);
    code_of = {ID_W{1'b1}};
    for (int i = 0; i < N; i++) if (g[i]) code_of = ID_W'(i);
  endfunction

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_masked_not_granted_R4: assert property (@(posedge clk) disable iff (rst)
    hresp[1] |=> (grant & $past(mask)) == '0);

  assert_hold_keeps_grant_R6: assert property (@(posedge clk) disable iff (rst)
    (hold && hready && htrans == 2'b11 && !hresp[1] &&
     (32'(cnt) + 1) < (32'(len) - 1)) |=> $stable(grant));

  assert_owner_follows_R8: assert property (@(posedge clk) disable iff (rst)
    hready |=> owner == code_of($past(grant)));

  assert_stall_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!hready && !hresp[1]) |=> $stable(grant));
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(
  .N(N_MASTERS), .ID_W(ID_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .grant(grant_o), .owner(owner_o),
  .hready(hready_i), .htrans(htrans_i), .hresp(hresp_i),
  .mask(mask_q), .hold(hold_q), .cnt(cnt_q), .len(len_q)
);

// File: tb/prio_bus_arbiter_bench.sv
module prio_bus_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] req;
  logic [4:0] rel;
  logic       hready;
  logic [1:0] htrans;
  logic [2:0] hburst;
  logic [1:0] hresp;
  logic [4:0] grant, grant_nh;
  logic [3:0] owner, owner_nh;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_bus_arbiter u_prio_bus_arbiter (
    .clk(clk), .rst(rst), .req_i(req), .split_release_i(rel),
    .hready_i(hready), .htrans_i(htrans), .hburst_i(hburst), .hresp_i(hresp),
    .grant_o(grant), .owner_o(owner)
  );

  prio_bus_arbiter #(.HOLD_EN(1'b0)) u_prio_bus_arbiter_nohold (
    .clk(clk), .rst(rst), .req_i(req), .split_release_i(rel),
    .hready_i(hready), .htrans_i(htrans), .hburst_i(hburst), .hresp_i(hresp),
    .grant_o(grant_nh), .owner_o(owner_nh)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req_tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req_tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    hready = 1'b1; htrans = 2'b00; hburst = 3'b000; hresp = 2'b00; rel = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1; req = '0; idle_bus();
    step(2);
    rst = 1'b0;
    chk("R3 reset grant", grant, 5'b00001);
    chk("R3 reset owner", {1'b0, owner}, 5'b00000);
    step(1);
    chk("R3 default idle", grant, 5'b00001);
  endtask

  task automatic t_priority();
    req = 5'b01010; step(1);
    chk("R2 pick 3 over 1", grant, 5'b01000);
    chk("R1 owner lags", {1'b0, owner}, 5'b00000);
    step(1);
    chk("R8 owner code 3", {1'b0, owner}, 5'b00011);
    req = 5'b11111; step(2);
    chk("R2 pick 4", grant, 5'b10000);
    chk("R8 owner code 4", {1'b0, owner}, 5'b00100);
    hready = 1'b0; req = 5'b00100; step(2);
    chk("R9 stalled grant", grant, 5'b10000);
    hready = 1'b1; step(1);
    chk("R2 pick 2", grant, 5'b00100);
    req = '0; step(2);
    chk("R3 default master", grant, 5'b00001);
    chk("R3 default owner", {1'b0, owner}, 5'b00000);
  endtask

  task automatic t_split(input int m, input logic [4:0] req_during,
                         input logic [4:0] exp_g, input string tag);
    req = 5'(1 << m); idle_bus(); step(3);
    req = req_during;
    hready = 1'b0; hresp = 2'b11; step(1);
    hready = 1'b1; step(1);
    chk({tag, " dummy on split"}, grant, exp_g);
    hresp = 2'b00; step(1);
    chk({tag, " dummy code"}, {1'b0, owner}, 5'b01111);
    req = 5'(1 << m); step(1);
    chk("R4 masked stays out", grant, exp_g);
    rel = 5'(1 << m); step(1);
    rel = '0; step(1);
    chk("R4 release regrant", grant, 5'(1 << m));
    req = '0; step(2);
  endtask

  task automatic t_hold();
    req = 5'b00100; idle_bus(); step(2);
    chk("R6 setup owner 2", grant, 5'b00100);
    req = 5'b10100; htrans = 2'b10; hburst = 3'b011; step(1);
    chk("R6 held at start", grant, 5'b00100);
    chk("R10 nohold switches", grant_nh, 5'b10000);
    htrans = 2'b11; req = 5'b10000; step(1);
    chk("R6 held after drop", grant, 5'b00100);
    step(1);
    chk("R6 release at penultimate", grant, 5'b10000);
    htrans = 2'b00; step(1);
    req = 5'b10001; htrans = 2'b10; hburst = 3'b100; step(1);
    htrans = 2'b11; req = 5'b00001; step(1);
    chk("R6 held 8-beat", grant, 5'b10000);
    hready = 1'b0; hresp = 2'b10; step(1);
    chk("R7 retry overrides hold", grant, 5'b00001);
    hready = 1'b1; htrans = 2'b00; step(1);
    hresp = 2'b00; step(1);
    req = 5'b00011; htrans = 2'b10; hburst = 3'b001; step(1);
    chk("R10 undefined INCR not held", grant, 5'b00010);
    htrans = 2'b00; req = '0; step(2);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_priority();
    t_split(3, 5'b01000, 5'b00000, "R5 all requesters masked");
    t_split(0, 5'b00000, 5'b00000, "R5 master0 masked");
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule